// File: doc/BRIEF.md
# Pattern-Triggered Toggling Level FSM

This block watches a serial bit stream and keeps a single output level. Each time the three-bit pattern zero, one, one completes on the input, the level inverts. It then stays at that value until the next completion. The block is a Moore machine, so the output follows only the current state and never the input directly.

Six states track how far the pattern has progressed, three for each output level. They are held in three flip-flops. The codes are chosen so that each group of related states forms a contiguous block in a K-map, and so that every legal transition changes only one state bit. A completed pattern counts only if a zero came before its two ones, so a long run of ones after a completion does not toggle the level again. The two unused codes are illegal, and the machine returns to the idle low-level state on the next clock if it ever lands on one. By default the output comes from a dedicated flip-flop, which is loaded from the next-state decode.

Top module: `pattern_toggle_fsm`

## Requirements
- R1: `rst` is synchronous and active high. At the first rising edge with `rst` high, `z` becomes 0, and it stays 0 while `rst` stays high.
- R2: When `x` is sampled as 0, then 1, then 1 on three consecutive rising edges, `z` inverts right after the third of those edges.
- R3: At any edge that does not complete the 0,1,1 pattern, `z` keeps its value.
- R4: A run of 1s after a completed pattern does not toggle `z` again. Only a new 0 followed by 1,1 does.
- R5: Patterns join back to back. The stream 0,1,1,0,1,1 toggles `z` twice, and any number of leading 0s before 1,1 counts as a single occurrence.
- R6: Bits sampled before the first 0 after reset cannot form part of a pattern. The stream 1,1 right after reset leaves `z` at 0, and 1,0,1,1 toggles it once.
- R7: `z` depends only on the state. A change of `x` between clock edges does not change `z` before the next rising edge.
- R8: Over long random streams, `z` after every edge equals a level that inverts on each 0,1,1 match seen on the last three sampled bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to the idle low-level state |
| x | input | 1 | Serial input bit, sampled on each rising edge |
| z | output | 1 | Toggling level output |

## Verification
The assertions assume that `x` is a clean 0 or 1 at every rising edge, and that the pattern history they keep starts empty with each reset. After a reset, a 1 therefore cannot be treated as part of a pattern. The bench drives `x` only on falling edges, so every sampled value is settled a half period before it is used. It also holds `rst` for at least two edges, so the design and the assertion history restart together. The only change of `x` away from a falling edge comes in the Moore scenario, and there the bench checks `z` before the next rising edge.

// File: rtl/pattern_toggle_pkg.sv
package pattern_toggle_pkg;

  localparam int STATE_W = 3;

  typedef logic [STATE_W-1:0] state_t;

  // Low-level group forms one K-map block, high-level group another.
  // Every legal transition flips a single state bit.
  localparam state_t S_IDLE_LO = 3'b000;  // low level, no progress
  localparam state_t S_ZERO_LO = 3'b001;  // low level, seen 0
  localparam state_t S_ONE_LO  = 3'b011;  // low level, seen 0,1
  localparam state_t S_IDLE_HI = 3'b111;  // high level, no progress
  localparam state_t S_ZERO_HI = 3'b101;  // high level, seen 0
  localparam state_t S_ONE_HI  = 3'b100;  // high level, seen 0,1

  function automatic state_t next_state(input state_t cur, input logic bit_in);
    state_t nxt;
    case (cur)
      S_IDLE_LO: nxt = bit_in ? S_IDLE_LO : S_ZERO_LO;
      S_ZERO_LO: nxt = bit_in ? S_ONE_LO  : S_ZERO_LO;
      S_ONE_LO:  nxt = bit_in ? S_IDLE_HI : S_ZERO_LO;
      S_IDLE_HI: nxt = bit_in ? S_IDLE_HI : S_ZERO_HI;
      S_ZERO_HI: nxt = bit_in ? S_ONE_HI  : S_ZERO_HI;
      S_ONE_HI:  nxt = bit_in ? S_IDLE_LO : S_ZERO_HI;
      default:   nxt = S_IDLE_LO;  // illegal code recovers to idle
    endcase
    return nxt;
  endfunction

  function automatic logic level_of(input state_t cur);
    logic lvl;
    case (cur)
      S_IDLE_HI, S_ZERO_HI, S_ONE_HI: lvl = 1'b1;
      default:                        lvl = 1'b0;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/pattern_toggle_next.sv
module pattern_toggle_next
  import pattern_toggle_pkg::*;
(
  input  state_t cur_st,
  input  logic   bit_in,
  output state_t nxt_st
);

  always_comb begin
    nxt_st = next_state(cur_st, bit_in);
  end

endmodule

// File: rtl/pattern_toggle_state_reg.sv
module pattern_toggle_state_reg
  import pattern_toggle_pkg::*;
#(
  parameter state_t RESET_CODE = S_IDLE_LO
) (
  input  logic   clk,
  input  logic   rst,
  input  state_t nxt_st,
  output state_t cur_st
);

  always_ff @(posedge clk) begin
    if (rst) cur_st <= RESET_CODE;
    else     cur_st <= nxt_st;
  end

endmodule

// File: rtl/pattern_toggle_out.sv
module pattern_toggle_out
  import pattern_toggle_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic   clk,
  input  logic   rst,
  input  state_t cur_st,
  input  state_t nxt_st,
  output logic   lvl
);

  generate
    if (REG_OUT) begin : g_reg
      logic lvl_q;
      always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= level_of(nxt_st);
      end
      assign lvl = lvl_q;
    end else begin : g_dec
      logic lvl_c;
      always_comb lvl_c = level_of(cur_st);
      assign lvl = lvl_c;
    end
  endgenerate

  logic unused_ok;
  assign unused_ok = ^{cur_st, nxt_st, clk, rst};

endmodule

// File: rtl/pattern_toggle_fsm.sv
module pattern_toggle_fsm
  import pattern_toggle_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic x,
  output logic z
);

  state_t st_q;
  state_t st_d;

  pattern_toggle_next u_next (
    .cur_st (st_q),
    .bit_in (x),
    .nxt_st (st_d)
  );

  pattern_toggle_state_reg #(
    .RESET_CODE (S_IDLE_LO)
  ) u_sreg (
    .clk    (clk),
    .rst    (rst),
    .nxt_st (st_d),
    .cur_st (st_q)
  );

  pattern_toggle_out #(
    .REG_OUT (REG_OUT)
  ) u_out (
    .clk    (clk),
    .rst    (rst),
    .cur_st (st_q),
    .nxt_st (st_d),
    .lvl    (z)
  );

endmodule

// File: rtl/pattern_toggle_fsm_chk.sv
module pattern_toggle_fsm_chk
  import pattern_toggle_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input logic   x,
  input logic   z,
  input state_t st
);

  logic hist_old, hist_new;
  logic match_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_old <= 1'b1;
      hist_new <= 1'b1;
    end else begin
      hist_old <= hist_new;
      hist_new <= x;
    end
  end

  assign match_now = !hist_old && hist_new && x;

  AST_RESET_LOW: assert property (@(posedge clk) rst |=> !z);  // R1
  AST_TOGGLE_ON_MATCH: assert property (@(posedge clk) disable iff (rst) match_now |=> (z != $past(z)));  // R2
  AST_HOLD_OTHERWISE: assert property (@(posedge clk) disable iff (rst) !match_now |=> (z == $past(z)));  // R3
  AST_LEVEL_FROM_STATE: assert property (@(posedge clk) disable iff (rst) z == st[2]);  // R7
  AST_SINGLE_BIT_STEP: assert property (@(posedge clk) disable iff (rst) $countones(st ^ $past(st)) <= 1);  // R7

endmodule

bind pattern_toggle_fsm pattern_toggle_fsm_chk u_chk (
  .clk (clk),
  .rst (rst),
  .x   (x),
  .z   (z),
  .st  (st_q)
);

// File: tb/pattern_toggle_fsm_test.sv
`timescale 1ns/1ps
module pattern_toggle_fsm_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x   = 1'b0;
  logic z;

  int n_checks = 0;
  int n_fails  = 0;

  logic exp_z;
  logic h_old, h_new;

  always #5 clk = ~clk;

  pattern_toggle_fsm uut (
    .clk (clk),
    .rst (rst),
    .x   (x),
    .z   (z)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: z=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    x   = 1'b1;
    @(posedge clk); #1;
    check("R1", z, 1'b0);
    @(posedge clk); #1;
    check("R1", z, 1'b0);
    @(negedge clk);
    rst   = 1'b0;
    exp_z = 1'b0;
    h_old = 1'b1;
    h_new = 1'b1;
  endtask

  // drive one bit on the falling edge, update model, check after rising edge
  task automatic step(input logic b, input string req);
    @(negedge clk);
    x = b;
    @(posedge clk); #1;
    if (!h_old && h_new && b) exp_z = ~exp_z;
    h_old = h_new;
    h_new = b;
    check(req, z, exp_z);
  endtask

  task automatic t_basic();
    do_reset();
    step(1'b0, "R3"); step(1'b1, "R3");
    step(1'b1, "R2"); check("R2", z, 1'b1);
    step(1'b0, "R3"); step(1'b1, "R3");
    step(1'b1, "R2"); check("R2", z, 1'b0);
  endtask

  task automatic t_run_of_ones();
    do_reset();
    step(1'b0, "R4"); step(1'b1, "R4"); step(1'b1, "R4");
    for (int i = 0; i < 6; i++) step(1'b1, "R4");
    check("R4", z, 1'b1);
    step(1'b0, "R4"); step(1'b1, "R4"); step(1'b1, "R4");
    check("R4", z, 1'b0);
  endtask

  task automatic t_back_to_back();
    do_reset();
    step(1'b0, "R5"); step(1'b0, "R5"); step(1'b0, "R5");
    step(1'b1, "R5"); step(1'b1, "R5");
    check("R5", z, 1'b1);
    step(1'b0, "R5"); step(1'b1, "R5"); step(1'b1, "R5");
    check("R5", z, 1'b0);
    step(1'b0, "R5"); step(1'b1, "R5"); step(1'b0, "R5");
    step(1'b1, "R5"); step(1'b1, "R5");
    check("R5", z, 1'b1);
  endtask

  task automatic t_after_reset();
    do_reset();
    step(1'b1, "R6"); step(1'b1, "R6");
    check("R6", z, 1'b0);
    do_reset();
    step(1'b1, "R6"); step(1'b0, "R6"); step(1'b1, "R6"); step(1'b1, "R6");
    check("R6", z, 1'b1);
  endtask

  task automatic t_moore();
    do_reset();
    step(1'b0, "R7"); step(1'b1, "R7");
    @(negedge clk);
    x = 1'b1;
    #2; check("R7", z, 1'b0);
    x = 1'b0;
    #1; check("R7", z, 1'b0);
    x = 1'b1;
    @(posedge clk); #1;
    exp_z = ~exp_z;
    h_old = h_new;
    h_new = 1'b1;
    check("R7", z, 1'b1);
    @(negedge clk);
    x = 1'b0;
    #1; check("R7", z, 1'b1);
  endtask

  task automatic t_random();
    logic [31:0] lfsr;
    lfsr = 32'hACE1_2468;
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[3] & (lfsr[9] | ~lfsr[17]), "R8");
      if (i == 1500) do_reset();
    end
  endtask

  initial begin
    t_basic();
    t_run_of_ones();
    t_back_to_back();
    t_after_reset();
    t_moore();
    t_random();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule